// File: doc/BRIEF.md
# Scale-Range Filter Table Selector

This block picks the interpolation filter table that suits a resize step. A resampling engine gives it a horizontal and a vertical increment, each in 6.10 fixed point. An increment is the inverse of the scale factor, so 0x0400 means 1:1. The block keeps two banks of range entries, one per direction. Each entry holds an exclusive lower bound, an inclusive upper bound and the base address of a coefficient table. For each direction the block returns the base address of the winning entry.

Before the search, the block can adjust both increments for chroma resampling. Producing 4:2:0 chroma from a full-resolution source doubles them. Expanding 4:2:0 chroma to a full-resolution target halves them. The adjusted increments are also brought out, so the engine steps with the same values that chose the tables.

Entries are loaded through a single write port. Each write names a direction, an entry index, both bounds and an address. Lookup has one cycle of latency.

Top module: `scale_filter_select`

## Requirements
- R1: During reset every entry of both banks is cleared to min 0, max 0, address 0, and all four outputs are 0. With no entry written, a lookup returns address 0.
- R2: A write with `wrEn`=1 stores `wrMin`, `wrMax` and `wrAddr` into entry `wrIdx` of the horizontal bank when `wrDir`=0, or of the vertical bank when `wrDir`=1. The other bank is left unchanged.
- R3: An entry matches an increment when min < increment <= max. An increment equal to min does not match that entry. An increment equal to max does match.
- R4: Entries are searched from the highest index down to index 1. The first entry that matches wins, so the highest matching index is chosen.
- R5: When no entry with index 1 or above matches, the address of entry 0 is returned, whatever range entry 0 holds.
- R6: The horizontal bank is searched with the adjusted horizontal increment. The vertical bank is searched with the adjusted vertical increment. The two searches are independent.
- R7: `chromaMode`=2'b01 (full-resolution to 4:2:0 chroma) doubles both increments, keeping the low 16 bits, before the search.
- R8: `chromaMode`=2'b10 (4:2:0 to full resolution) halves both increments, rounding down, before the search.
- R9: `chromaMode`=2'b00 and 2'b11 pass both increments through unchanged.
- R10: The inputs present at a rising clock edge determine all four outputs after that edge. The search uses the table contents from before any write made at that same edge. A write becomes visible to lookups at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrDir | input | 1 | Bank select for the write: 0 horizontal, 1 vertical |
| wrIdx | input | IDX_W (3) | Entry index to write |
| wrMin | input | INC_W (16) | Exclusive lower bound, 6.10 |
| wrMax | input | INC_W (16) | Inclusive upper bound, 6.10 |
| wrAddr | input | ADDR_W (32) | Coefficient table base address |
| hInc | input | INC_W (16) | Horizontal increment, 6.10 |
| vInc | input | INC_W (16) | Vertical increment, 6.10 |
| chromaMode | input | 2 | 00/11 pass, 01 double, 10 halve |
| hAddr | output | ADDR_W (32) | Selected horizontal table address |
| vAddr | output | ADDR_W (32) | Selected vertical table address |
| hIncUsed | output | INC_W (16) | Adjusted horizontal increment |
| vIncUsed | output | INC_W (16) | Adjusted vertical increment |

## Verification
The bench places increments exactly on a lower bound and exactly on an upper bound. A design that swaps which bound is inclusive returns a neighbouring table at those points. Overlapping ranges test the search order: searching upward would return the lower index. An increment outside every range must fall back to entry 0 even when entry 0 has a range of its own, and a design that tests entry 0 like the others would return a wrong entry. The bench also doubles an increment with its top bit set and halves an odd one, catching carry-out and rounding faults. It also presents a lookup in the same cycle as a write, which catches a write that is forwarded into the search too early.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    CHROMA_PASS  = 2'b00,
    CHROMA_DBL   = 2'b01,
    CHROMA_HALF  = 2'b10,
    CHROMA_PASS2 = 2'b11
  } chroma_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hWe;
    logic vWe;
    logic incDbl;
    logic incHalf;
  } sfs_strobe_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic        wrEn,
  input  logic        wrDir,
  input  logic [1:0]  chromaMode,
  output sfs_strobe_t strb
);
  always_comb begin
    strb.hWe     = wrEn && !wrDir;
    strb.vWe     = wrEn && wrDir;
    strb.incDbl  = (chroma_mode_e'(chromaMode) == CHROMA_DBL);
    strb.incHalf = (chroma_mode_e'(chromaMode) == CHROMA_HALF);
  end
endmodule

// File: rtl/sfs_bank.sv
module sfs_bank #(
  parameter int DEPTH  = 8,
  parameter int INC_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [IDX_W-1:0]  wIdx,
  input  logic [INC_W-1:0]  wMin,
  input  logic [INC_W-1:0]  wMax,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [INC_W-1:0]  inc,
  output logic [ADDR_W-1:0] selAddr
);
  logic [INC_W-1:0]  loBound [DEPTH];
  logic [INC_W-1:0]  hiBound [DEPTH];
  logic [ADDR_W-1:0] baseAddr [DEPTH];
  logic [IDX_W-1:0]  hitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        loBound[i]  <= '0;
        hiBound[i]  <= '0;
        baseAddr[i] <= '0;
      end
    end else if (we) begin
      loBound[wIdx]  <= wMin;
      hiBound[wIdx]  <= wMax;
      baseAddr[wIdx] <= wAddr;
    end
  end

  // ascending scan, later hit overrides: highest index wins, 0 is default
  always_comb begin
    hitIdx = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if ((loBound[i] < inc) && (inc <= hiBound[i])) hitIdx = IDX_W'(i);
    end
  end

  assign selAddr = baseAddr[hitIdx];
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int INC_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfs_strobe_t       strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [INC_W-1:0]  wrMin,
  input  logic [INC_W-1:0]  wrMax,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [INC_W-1:0]  hInc,
  input  logic [INC_W-1:0]  vInc,
  output logic [ADDR_W-1:0] hAddr,
  output logic [ADDR_W-1:0] vAddr,
  output logic [INC_W-1:0]  hIncUsed,
  output logic [INC_W-1:0]  vIncUsed
);
  logic [INC_W-1:0]  rawInc  [2];
  logic [INC_W-1:0]  adjInc  [2];
  logic [ADDR_W-1:0] bankSel [2];
  logic              bankWe  [2];

  assign rawInc[0] = hInc;
  assign rawInc[1] = vInc;
  assign bankWe[0] = strb.hWe;
  assign bankWe[1] = strb.vWe;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    always_comb begin
      if (strb.incDbl)       adjInc[g] = {rawInc[g][INC_W-2:0], 1'b0};
      else if (strb.incHalf) adjInc[g] = {1'b0, rawInc[g][INC_W-1:1]};
      else                   adjInc[g] = rawInc[g];
    end

    sfs_bank #(.DEPTH(DEPTH), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .we      (bankWe[g]),
      .wIdx    (wrIdx),
      .wMin    (wrMin),
      .wMax    (wrMax),
      .wAddr   (wrAddr),
      .inc     (adjInc[g]),
      .selAddr (bankSel[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hAddr    <= '0;
      vAddr    <= '0;
      hIncUsed <= '0;
      vIncUsed <= '0;
    end else begin
      hAddr    <= bankSel[0];
      vAddr    <= bankSel[1];
      hIncUsed <= adjInc[0];
      vIncUsed <= adjInc[1];
    end
  end
endmodule

// File: rtl/scale_filter_select.sv
module scale_filter_select
  import sfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int INC_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrDir,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [INC_W-1:0]  wrMin,
  input  logic [INC_W-1:0]  wrMax,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [INC_W-1:0]  hInc,
  input  logic [INC_W-1:0]  vInc,
  input  logic [1:0]        chromaMode,
  output logic [ADDR_W-1:0] hAddr,
  output logic [ADDR_W-1:0] vAddr,
  output logic [INC_W-1:0]  hIncUsed,
  output logic [INC_W-1:0]  vIncUsed
);
  sfs_strobe_t strb;

  sfs_ctrl u_ctrl (
    .wrEn       (wrEn),
    .wrDir      (wrDir),
    .chromaMode (chromaMode),
    .strb       (strb)
  );

  sfs_datapath #(.DEPTH(DEPTH), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .wrMin    (wrMin),
    .wrMax    (wrMax),
    .wrAddr   (wrAddr),
    .hInc     (hInc),
    .vInc     (vInc),
    .hAddr    (hAddr),
    .vAddr    (vAddr),
    .hIncUsed (hIncUsed),
    .vIncUsed (vIncUsed)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int DEPTH  = 8,
  parameter int INC_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrDir,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [INC_W-1:0]  wrMin,
  input logic [INC_W-1:0]  wrMax,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [INC_W-1:0]  hInc,
  input logic [INC_W-1:0]  vInc,
  input logic [1:0]        chromaMode,
  input logic [ADDR_W-1:0] hAddr,
  input logic [ADDR_W-1:0] vAddr,
  input logic [INC_W-1:0]  hIncUsed,
  input logic [INC_W-1:0]  vIncUsed
);
  assert_double_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(chromaMode) == 2'b01) |->
      (hIncUsed == ($past(hInc) << 1)) && (vIncUsed == ($past(vInc) << 1)));

  assert_halve_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(chromaMode) == 2'b10) |->
      (hIncUsed == ($past(hInc) >> 1)) && (vIncUsed == ($past(vInc) >> 1)));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(chromaMode) == 2'b00 || $past(chromaMode) == 2'b11)) |->
      (hIncUsed == $past(hInc)) && (vIncUsed == $past(vInc)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !wrEn && !$past(wrEn) && $stable(hInc) && $stable(vInc)
     && $stable(chromaMode)) |=> ($stable(hAddr) && $stable(vAddr)));
endmodule

bind scale_filter_select sfs_checker #(.DEPTH(DEPTH), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/scale_filter_select_bench.sv
`timescale 1ns/1ps
module scale_filter_select_bench;
  localparam int DEPTH = 8, INC_W = 16, ADDR_W = 32, IDX_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, wrDir = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [INC_W-1:0]  wrMin = '0, wrMax = '0, hInc = '0, vInc = '0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [1:0]        chromaMode = 2'b00;
  logic [ADDR_W-1:0] hAddr, vAddr;
  logic [INC_W-1:0]  hIncUsed, vIncUsed;

  int vectors = 0, miscompares = 0;
  logic [INC_W-1:0]  refMin  [2][DEPTH];
  logic [INC_W-1:0]  refMax  [2][DEPTH];
  logic [ADDR_W-1:0] refAddr [2][DEPTH];

  always #2.5 clk = ~clk;

  scale_filter_select #(.DEPTH(DEPTH), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_scale_filter_select (.*);

  function automatic logic [INC_W-1:0] adjust(logic [INC_W-1:0] inc, logic [1:0] m);
    if (m == 2'b01) return INC_W'({inc, 1'b0});
    if (m == 2'b10) return inc >> 1;
    return inc;
  endfunction

  function automatic logic [ADDR_W-1:0] pick(int d, logic [INC_W-1:0] inc);
    for (int i = DEPTH - 1; i > 0; i--)
      if (refMin[d][i] < inc && inc <= refMax[d][i]) return refAddr[d][i];
    return refAddr[d][0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic d, int idx, logic [INC_W-1:0] mn, logic [INC_W-1:0] mx,
                    logic [ADDR_W-1:0] a);
    @(negedge clk);
    wrEn = 1'b1; wrDir = d; wrIdx = IDX_W'(idx); wrMin = mn; wrMax = mx; wrAddr = a;
    @(negedge clk);
    wrEn = 1'b0;
    refMin[d][idx] = mn; refMax[d][idx] = mx; refAddr[d][idx] = a;
  endtask

  // lookup and compare; inputs change at negedge, result sampled next negedge
  task automatic look(string req, logic [INC_W-1:0] h, logic [INC_W-1:0] v, logic [1:0] m);
    logic [INC_W-1:0] ah, av;
    @(negedge clk);
    hInc = h; vInc = v; chromaMode = m;
    ah = adjust(h, m); av = adjust(v, m);
    @(negedge clk);
    chk(req, 32'(hIncUsed), 32'(ah));
    chk(req, 32'(vIncUsed), 32'(av));
    chk(req, hAddr, pick(0, ah));
    chk(req, vAddr, pick(1, av));
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] oldH;
    void'($urandom(32'd1357));
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < DEPTH; i++) begin
        refMin[d][i] = '0; refMax[d][i] = '0; refAddr[d][i] = '0;
      end
    #12;
    // R1 reset state
    chk("R1", hAddr, 0); chk("R1", vAddr, 0);
    chk("R1", 32'(hIncUsed), 0); chk("R1", 32'(vIncUsed), 0);
    @(negedge clk); rstN = 1'b1;
    look("R1", 16'h0400, 16'h0400, 2'b00);
    // R5 fallback: entry 0 range excludes the increment
    wr(1'b0, 0, 16'd100, 16'd200, 32'hA0A0_0000);
    look("R5", 16'h1F00, 16'h0400, 2'b00);
    chk("R5", hAddr, 32'hA0A0_0000);
    // R2 vertical bank untouched by horizontal writes
    chk("R2", vAddr, 32'h0);
    // R4 overlap: entries 2 and 5
    wr(1'b0, 2, 16'h0300, 16'h0500, 32'hB2);
    wr(1'b0, 5, 16'h0380, 16'h0600, 32'hB5);
    look("R4", 16'h0400, 16'h0400, 2'b00);
    chk("R4", hAddr, 32'hB5);
    look("R3", 16'h0300, 16'h0, 2'b00);
    chk("R3", hAddr, 32'hA0A0_0000);
    look("R3", 16'h0600, 16'h0, 2'b00);
    chk("R3", hAddr, 32'hB5);
    look("R3", 16'h0601, 16'h0, 2'b00);
    chk("R3", hAddr, 32'hA0A0_0000);
    look("R3", 16'h0320, 16'h0, 2'b00);
    chk("R3", hAddr, 32'hB2);
    // R6 distinct per direction
    wr(1'b1, 3, 16'h0100, 16'h0800, 32'hC3);
    look("R6", 16'h0400, 16'h0200, 2'b00);
    chk("R6", vAddr, 32'hC3);
    chk("R6", hAddr, 32'hB5);
    // R7 doubling with wrap, R8 halving of odd value, R9 mode 11
    look("R7", 16'h9000, 16'h0200, 2'b01);
    chk("R7", 32'(hIncUsed), 32'h2000);
    look("R8", 16'h0401, 16'h0801, 2'b10);
    chk("R8", 32'(hIncUsed), 32'h0200);
    look("R9", 16'h0333, 16'h0444, 2'b11);
    // R10 write and lookup in the same cycle: old table used first
    look("R10", 16'h0700, 16'h0, 2'b00);
    oldH = hAddr;
    @(negedge clk);
    wrEn = 1'b1; wrDir = 1'b0; wrIdx = 3'd7; wrMin = 16'h0650; wrMax = 16'h0750; wrAddr = 32'hD7;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10", hAddr, oldH);
    refMin[0][7] = 16'h0650; refMax[0][7] = 16'h0750; refAddr[0][7] = 32'hD7;
    @(negedge clk);
    chk("R10", hAddr, 32'hD7);
    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [INC_W-1:0] mn;
        mn = INC_W'($urandom_range(0, 16'h1000));
        wr(1'($urandom_range(0, 1)), $urandom_range(0, DEPTH - 1), mn,
           mn + INC_W'($urandom_range(0, 16'h0C00)), $urandom);
      end
      look("R6", INC_W'($urandom_range(0, 16'h2000)), INC_W'($urandom_range(0, 16'h2000)),
           2'($urandom_range(0, 3)));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule